// File: doc/BRIEF.md
# Serial ADC Sampling Sequencer

This block sits on the host side of a multichannel successive-approximation converter. The converter has one line that does two jobs: a rising edge on it starts a conversion, and holding it low opens the serial port. The serial port has a clock, a data line into the converter and a data line out of it. The block accepts channel requests on a valid/ready stream. Each request gives a channel number, single-ended or differential mode, common-pin mode and unipolar or bipolar format. The block turns the request into the converter's configuration word and runs one serial frame for it.

A frame has four steps. The block waits until the conversion started by the previous rising edge has had its worst-case time. It then lowers the line and clocks 16 bits. The previous result comes in and the new configuration goes out. The line is held low for the minimum acquisition time and then raised again. That rising edge starts the conversion for the configuration just sent, and the line then stays high so that the converter can nap. A result therefore always belongs to the configuration sent one frame earlier. The block returns that configuration's tag and format flag alongside the data on a valid/ready result stream.

Back-pressure rules: a request is taken only when the sequencer is idle and no result is waiting. A result stays valid and unchanged until `res_ready` is seen high. While a result is waiting, no new frame starts.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the convert line is high, the serial clock is low, `res_valid` is 0 and `req_ready` is 1.
- R2: The configuration word is the first 7 of the 16 bits sent MSB first on `adc_sdi`, and the other 9 bits are 0. Its bits, from first to last, are: SD = 1 for single-ended and 0 for differential; OS = chan[0]; S1 = chan[2]; S0 = chan[1]; COM; UNI = 1 for unipolar; SLEEP = 0.
- R3: The convert line falls only after it has been high for at least CONV_CYC clock cycles.
- R4: Each low period of the convert line lasts at least ACQ_CYC cycles and contains exactly FRAME_BITS rising serial clock edges.
- R5: The serial clock toggles only while the line is low. `adc_sdo` is sampled on the rising serial clock edges, and `res_data` holds those bits MSB first.
- R6: Each result carries the data and tag of the configuration sent in the previous frame. The first frame after reset produces no result.
- R7: A request for single-ended channel 7 with COM = 1 is refused. `req_reject` pulses for one cycle, no frame runs, and the stored configuration is not changed.
- R8: While `res_valid` is high and `res_ready` is low, the result and its tag stay stable and `req_ready` is 0.
- R9: The convert line goes high at the end of each frame and stays high while the sequencer is idle.
- R10: `res_unipolar` is the format flag of the result's own configuration: 1 means straight binary and 0 means two's complement. `res_chan`, `res_diff` and `res_com` carry that configuration's channel, mode and common-pin setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready |
| req_chan | input | 3 | Requested channel number |
| req_diff | input | 1 | 1 = differential pair, 0 = single-ended |
| req_com | input | 1 | 1 = channel 7 serves as the common input |
| req_unipolar | input | 1 | 1 = unipolar (straight binary) result |
| req_reject | output | 1 | One-cycle pulse when a request is refused |
| adc_cnv | output | 1 | Combined convert start / select line |
| adc_sck | output | 1 | Serial clock to the converter |
| adc_sdi | output | 1 | Configuration bits to the converter |
| adc_sdo | input | 1 | Result bits from the converter |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_data | output | 16 | Result word |
| res_chan | output | 3 | Channel of the result's configuration |
| res_diff | output | 1 | Mode of the result's configuration |
| res_com | output | 1 | Common-pin flag of the result's configuration |
| res_unipolar | output | 1 | Format flag of the result |

## Verification
The bench models the converter. The model measures how long the line stays high before it falls and how long it stays low before it rises, so a design that lowered the line early, or cut the acquisition window short, would fail the timing checks. The bench checks that results come one frame late: a design that tagged a result with the request just sent, or that produced a result on the first frame after reset, gives the wrong channel or an extra result. A refused channel-7 request must leave the stored configuration untouched. A design that stored it anyway, or started a frame for it, would give the next result the wrong tag or show a line pulse while idle. Holding `res_ready` low shows whether a design drops or changes a waiting result, or accepts new work while one is pending.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W  = 3;
  localparam int CFG_W = 7;

  typedef struct packed {
    logic [CH_W-1:0] chan;
    logic            diff;
    logic            com;
    logic            uni;
  } req_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_CONV,
    ST_SHIFT,
    ST_ACQ
  } seq_state_t;
endpackage

// File: rtl/adc_seq_cfg_enc.sv
module adc_seq_cfg_enc
  import adc_seq_pkg::*;
(
  input  req_t             req,
  output logic [CFG_W-1:0] word,
  output logic             reject
);
  logic se;

  always_comb begin
    se     = ~req.diff;
    // order: single-ended, odd, select high, select low, common, unipolar, sleep
    word   = {se, req.chan[0], req.chan[2], req.chan[1], req.com, req.uni, 1'b0};
    // channel 7 cannot be both the common pin and the positive input
    reject = se & req.com & (req.chan == {CH_W{1'b1}});
  end
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CONV_CYC = 370,
  parameter int ACQ_CYC  = 168
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_hi,
  output logic conv_done,
  output logic acq_done
);
  localparam int HW = $clog2(CONV_CYC + 1);
  localparam int LW = $clog2(ACQ_CYC + 1);
  localparam logic [HW-1:0] HI_MAX = HW'(CONV_CYC);
  localparam logic [LW-1:0] LO_MAX = LW'(ACQ_CYC);

  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (line_hi) begin
      lo_cnt <= '0;
      if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt != LO_MAX) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  assign conv_done = (hi_cnt == HI_MAX);
  assign acq_done  = (lo_cnt == LO_MAX);
endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
  parameter int NBITS    = 16,
  parameter int SCK_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NBITS-1:0] tx_word,
  input  logic             sdo,
  output logic             sck,
  output logic             sdi,
  output logic             done,
  output logic [NBITS-1:0] rx_word
);
  localparam int DW = $clog2(SCK_HALF + 1);
  localparam int BW = $clog2(NBITS + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(SCK_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(NBITS - 1);

  logic             active;
  logic [DW-1:0]    div_cnt;
  logic [BW-1:0]    bit_cnt;
  logic [NBITS-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sck     <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_word <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active  <= 1'b1;
        sck     <= 1'b0;
        div_cnt <= '0;
        bit_cnt <= '0;
        tx_sh   <= tx_word;
      end else if (active) begin
        if (div_cnt == DIV_LAST) begin
          div_cnt <= '0;
          if (!sck) begin
            sck     <= 1'b1;
            rx_word <= {rx_word[NBITS-2:0], sdo};
          end else begin
            sck   <= 1'b0;
            tx_sh <= {tx_sh[NBITS-2:0], 1'b0};
            if (bit_cnt == BIT_LAST) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  assign sdi = tx_sh[NBITS-1];

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sck); // R5
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CONV_CYC   = 370,
  parameter int ACQ_CYC    = 168,
  parameter int SCK_HALF   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [2:0]            req_chan,
  input  logic                  req_diff,
  input  logic                  req_com,
  input  logic                  req_unipolar,
  output logic                  req_reject,
  output logic                  adc_cnv,
  output logic                  adc_sck,
  output logic                  adc_sdi,
  input  logic                  adc_sdo,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [FRAME_BITS-1:0] res_data,
  output logic [2:0]            res_chan,
  output logic                  res_diff,
  output logic                  res_com,
  output logic                  res_unipolar
);
  localparam int PAD_W = FRAME_BITS - CFG_W;

  seq_state_t       state;
  req_t             in_req, cur_cfg, prev_cfg, tag_q;
  logic [CFG_W-1:0] in_word, cur_word;
  logic             in_reject, have_prev, shift_start, shift_done;
  logic             conv_done, acq_done;
  logic [FRAME_BITS-1:0] rx_word;

  assign in_req = '{chan: req_chan, diff: req_diff, com: req_com, uni: req_unipolar};

  adc_seq_cfg_enc u_enc (
    .req    (in_req),
    .word   (in_word),
    .reject (in_reject)
  );

  adc_seq_timer #(.CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_hi   (adc_cnv),
    .conv_done (conv_done),
    .acq_done  (acq_done)
  );

  adc_seq_shift #(.NBITS(FRAME_BITS), .SCK_HALF(SCK_HALF)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (shift_start),
    .tx_word ({cur_word, {PAD_W{1'b0}}}),
    .sdo     (adc_sdo),
    .sck     (adc_sck),
    .sdi     (adc_sdi),
    .done    (shift_done),
    .rx_word (rx_word)
  );

  assign req_ready = (state == ST_IDLE) && !res_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      adc_cnv     <= 1'b1;
      req_reject  <= 1'b0;
      shift_start <= 1'b0;
      cur_cfg     <= '0;
      cur_word    <= '0;
      prev_cfg    <= '0;
      have_prev   <= 1'b0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      tag_q       <= '0;
    end else begin
      req_reject  <= 1'b0;
      shift_start <= 1'b0;
      if (res_valid && res_ready) res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            if (in_reject) begin
              req_reject <= 1'b1;
            end else begin
              cur_cfg  <= in_req;
              cur_word <= in_word;
              state    <= ST_WAIT_CONV;
            end
          end
        end
        ST_WAIT_CONV: begin
          if (conv_done) begin
            adc_cnv     <= 1'b0;
            shift_start <= 1'b1;
            state       <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (shift_done) state <= ST_ACQ;
        end
        ST_ACQ: begin
          if (acq_done) begin
            adc_cnv   <= 1'b1;
            state     <= ST_IDLE;
            if (have_prev) begin
              res_valid <= 1'b1;
              res_data  <= rx_word;
              tag_q     <= prev_cfg;
            end
            prev_cfg  <= cur_cfg;
            have_prev <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign res_chan     = tag_q.chan;
  assign res_diff     = tag_q.diff;
  assign res_com      = tag_q.com;
  assign res_unipolar = tag_q.uni;

  AST_FALL_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cnv) |-> conv_done); // R3
  AST_RISE_AFTER_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cnv) |-> acq_done); // R4
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(tag_q))); // R8
  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready); // R8
  AST_REJECT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |-> (adc_cnv && state == ST_IDLE)); // R7
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int CONV = 370;
  localparam int ACQ  = 168;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_diff = 1'b0, req_com = 1'b0, req_uni = 1'b0;
  logic [2:0] req_chan = '0;
  logic res_ready = 1'b0;
  logic adc_sdo = 1'b0;
  logic req_ready, req_reject, adc_cnv, adc_sck, adc_sdi, res_valid;
  logic res_diff, res_com, res_unipolar;
  logic [2:0] res_chan;
  logic [15:0] res_data;

  int total = 0, bad = 0;
  int frames = 0;
  bit started = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_diff(req_diff), .req_com(req_com),
    .req_unipolar(req_uni), .req_reject(req_reject), .adc_cnv(adc_cnv),
    .adc_sck(adc_sck), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_chan(res_chan), .res_diff(res_diff), .res_com(res_com),
    .res_unipolar(res_unipolar)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] enc(input logic [2:0] ch, input logic d, input logic c, input logic u);
    return {~d, ch[0], ch[2], ch[1], c, u, 1'b0};
  endfunction

  function automatic logic [15:0] conv_of(input logic [6:0] c);
    return {c, 2'b10, c};
  endfunction

  // converter model
  logic [15:0] m_out = 16'hDEAD;
  logic [15:0] m_sh = '0;
  logic [15:0] m_rx = '0;
  logic [6:0]  m_cfg = '0;
  int m_bits = 0;
  longint t_rise = 0, t_fall = 0;

  always @(negedge adc_cnv) if (started) begin
    chk(($time - t_rise) >= CONV * 10, "R3 high time", $time - t_rise, CONV * 10);
    t_fall = $time;
    m_bits = 0;
    m_sh = m_out;
    adc_sdo = m_sh[15];
  end

  always @(negedge adc_sck) if (started && !adc_cnv) begin
    m_sh = {m_sh[14:0], 1'b0};
    adc_sdo = m_sh[15];
  end

  always @(posedge adc_sck) if (started) begin
    chk(!adc_cnv, "R5 sck while line high", adc_cnv, 0);
    m_rx = {m_rx[14:0], adc_sdi};
    m_bits++;
  end

  always @(posedge adc_cnv) if (started) begin
    chk(($time - t_fall) >= ACQ * 10, "R4 low time", $time - t_fall, ACQ * 10);
    chk(m_bits == 16, "R4 bit count", m_bits, 16);
    chk(m_rx[8:0] == 9'd0, "R2 padding", m_rx[8:0], 0);
    m_cfg = m_rx[15:9];
    m_out = conv_of(m_cfg);
    frames++;
    t_rise = $time;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic send(input logic [2:0] ch, input logic d, input logic c, input logic u);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_chan = ch; req_diff = d; req_com = c; req_uni = u; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end();
    while (!(req_ready || res_valid)) @(negedge clk);
  endtask

  task automatic take(input logic [2:0] ch, input logic d, input logic c, input logic u, input string rq);
    wait_end();
    chk(res_valid, {rq, " result present"}, res_valid, 1);
    chk(res_data == conv_of(enc(ch, d, c, u)), {rq, " data"}, res_data, conv_of(enc(ch, d, c, u)));
    chk(res_chan == ch, {rq, " tag chan"}, res_chan, ch);
    chk(res_diff == d && res_com == c, {rq, " tag mode"}, {res_diff, res_com}, {d, c});
    chk(res_unipolar == u, "R10 format flag", res_unipolar, u);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid, "R8 released", res_valid, 0);
  endtask

  task automatic t_reset();
    chk(adc_cnv == 1'b1, "R1 line high", adc_cnv, 1);
    chk(adc_sck == 1'b0, "R1 sck low", adc_sck, 0);
    chk(res_valid == 1'b0, "R1 no result", res_valid, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
  endtask

  task automatic t_first();
    send(3'd3, 1'b0, 1'b0, 1'b1);
    wait_end();
    chk(!res_valid, "R6 no result on first frame", res_valid, 0);
    chk(frames == 1, "R4 one frame", frames, 1);
    chk(m_cfg == enc(3'd3, 1'b0, 1'b0, 1'b1), "R2 word se ch3", m_cfg, enc(3'd3, 1'b0, 1'b0, 1'b1));
  endtask

  task automatic t_second();
    send(3'd4, 1'b1, 1'b0, 1'b0);
    take(3'd3, 1'b0, 1'b0, 1'b1, "R6 lag");
    chk(m_cfg == enc(3'd4, 1'b1, 1'b0, 1'b0), "R2 word diff", m_cfg, enc(3'd4, 1'b1, 1'b0, 1'b0));
    chk(adc_cnv, "R9 line high after frame", adc_cnv, 1);
  endtask

  task automatic t_backpressure();
    logic [15:0] held;
    bit stable_ok = 1;
    send(3'd6, 1'b0, 1'b1, 1'b0);
    wait_end();
    held = res_data;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!res_valid || res_data != held || req_ready) stable_ok = 0;
    end
    chk(stable_ok, "R8 held under back-pressure", res_data, held);
    take(3'd4, 1'b1, 1'b0, 1'b0, "R8 held result");
    chk(m_cfg == enc(3'd6, 1'b0, 1'b1, 1'b0), "R2 word com ch6", m_cfg, enc(3'd6, 1'b0, 1'b1, 1'b0));
  endtask

  task automatic t_reject();
    int f0 = frames;
    bit line_ok = 1;
    send(3'd7, 1'b0, 1'b1, 1'b1);
    chk(req_reject, "R7 reject pulse", req_reject, 1);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!adc_cnv) line_ok = 0;
    end
    chk(line_ok, "R9 line parked high while idle", 0, 1);
    chk(frames == f0, "R7 no frame", frames, f0);
    send(3'd1, 1'b0, 1'b0, 1'b0);
    take(3'd6, 1'b0, 1'b1, 1'b0, "R7 config kept");
  endtask

  task automatic t_last();
    send(3'd5, 1'b1, 1'b1, 1'b1);
    take(3'd1, 1'b0, 1'b0, 1'b0, "R5 data order");
    chk(m_cfg == enc(3'd5, 1'b1, 1'b1, 1'b1), "R2 word diff com", m_cfg, enc(3'd5, 1'b1, 1'b1, 1'b1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    t_reset();
    t_first();
    t_second();
    t_backpressure();
    t_reject();
    t_last();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule